// File: doc/BRIEF.md
# Bit-Alias Access Bridge

This bridge sits between a bus master and a word-addressed memory or register space of 32-bit words. Any address inside a normal region is handed to the memory untouched, with full-width data, in a single transaction. A second, larger alias window is also decoded. Each 32-bit word in that window stands for exactly one bit of one target word, so a master can read or change a single bit with one ordinary word access.

An alias read fetches the target word and returns only the chosen bit. An alias write becomes an indivisible read-modify-write. The bridge reads the target word, replaces the one bit, and writes the word back. A lock signal toward the memory stays high across both halves, so no other master can access that word in between. The upstream ready stays low until the whole sequence has finished. An address that falls in neither window completes at once with an out-of-range flag and never reaches the memory.

Both ports use a request/ready handshake. The requester holds its request and fields until ready is seen high for one cycle. Read data and the error flag are valid in that same cycle.

Top module: `bitalias_bridge`

## Requirements
- R1: An address A with REGION_BASE <= A < REGION_BASE + 4*REGION_WORDS is forwarded unchanged as exactly one master transaction. Write data goes out at full width, and read data returns unchanged on s_rdata.
- R2: An address A with ALIAS_BASE <= A < ALIAS_BASE + 128*REGION_WORDS is an alias access. With offset O = A - ALIAS_BASE, the target word address is REGION_BASE + 4*(O >> 7) and the bit index is O[6:2]. O[1:0] is ignored.
- R3: An alias read issues one unlocked master read. It returns the selected bit in s_rdata[0], with s_rdata[31:1] zero, and issues no master write.
- R4: An alias write issues one master read and then one master write to the same target. Only the selected bit changes, and it takes s_wdata[0]. All other target bits and s_wdata[31:1] have no effect on the result.
- R5: m_lock is high on both master transactions of an alias write and stays high from the read until the write is accepted. It is low on alias reads and pass-through accesses.
- R6: s_ready stays low until the whole access, including any write-back, is done. It is then high for exactly one cycle, and no new request is taken while an access is in flight.
- R7: An address in neither window completes with s_err = 1 and s_rdata = 0, and it issues no master transaction.
- R8: While m_req is high and m_ready is low, m_req, m_we, m_addr and m_wdata stay unchanged.
- R9: During and right after synchronous reset, s_ready, m_req and m_lock are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Upstream request, held until s_ready |
| s_we | input | 1 | Upstream write (1) or read (0) |
| s_addr | input | 32 | Upstream byte address |
| s_wdata | input | 32 | Upstream write data |
| s_ready | output | 1 | One-cycle completion strobe |
| s_rdata | output | 32 | Read data, valid with s_ready |
| s_err | output | 1 | Out-of-range flag, valid with s_ready |
| m_req | output | 1 | Memory request, held until m_ready |
| m_we | output | 1 | Memory write (1) or read (0) |
| m_lock | output | 1 | Holds the target word across a read-modify-write |
| m_addr | output | 32 | Memory byte address |
| m_wdata | output | 32 | Memory write data |
| m_ready | input | 1 | Memory accepts the current request |
| m_rdata | input | 32 | Memory read data, valid with m_ready on a read |

## Verification
On every cycle, the assertions check the following properties:
- the master port holds its request stable while stalled;
- a locked read is always followed by a locked write to the same address;
- a write-back differs from the word read in at most one bit;
- alias read data carries nothing above bit 0;
- an out-of-range completion never coincides with a master request;
- ready is a single-cycle pulse.

Only the bench scenarios can show the rest. They compare against a reference memory to confirm that the right word and the right bit are chosen for each alias address, including the edge bits and the ignored low address bits. They also confirm that the stored word ends up correct and that words and bits never addressed stay untouched over many random accesses.

// File: rtl/bab_pkg.sv
package bab_pkg;

    localparam int ADDR_W      = 32;
    localparam int WORD_W      = 32;
    localparam int BIT_W       = $clog2(WORD_W);
    localparam int LANE_SHIFT  = $clog2(WORD_W / 8);
    // one alias word (4 bytes) per target bit -> alias bytes per target word
    localparam int ALIAS_SHIFT = LANE_SHIFT + BIT_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BIT_W-1:0]  bidx_t;

    typedef enum logic [1:0] {
        ACC_PASS,
        ACC_ALIAS,
        ACC_OOR
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_RD,
        ST_WR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      we;
        addr_t     tgt;
        bidx_t     bsel;
        word_t     wdata;
    } bus_req_t;

    function automatic logic in_window(addr_t a, addr_t base, addr_t span);
        addr_t off;
        off = a - base;
        return (a >= base) && (off < span);
    endfunction

    function automatic addr_t alias_target(addr_t off, addr_t region_base);
        return region_base + ((off >> ALIAS_SHIFT) << LANE_SHIFT);
    endfunction

    function automatic bidx_t alias_bit(addr_t off);
        return off[LANE_SHIFT +: BIT_W];
    endfunction

endpackage

// File: rtl/bab_decode.sv
module bab_decode
    import bab_pkg::*;
#(
    parameter addr_t       REGION_BASE  = 32'h2000_0000,
    parameter int unsigned REGION_WORDS = 1024,
    parameter addr_t       ALIAS_BASE   = 32'h2200_0000
) (
    input  logic     we,
    input  addr_t    addr,
    input  word_t    wdata,
    output bus_req_t req
);

    localparam addr_t REGION_SPAN = addr_t'(REGION_WORDS) << LANE_SHIFT;
    localparam addr_t ALIAS_SPAN  = addr_t'(REGION_WORDS) << ALIAS_SHIFT;

    addr_t alias_off;
    logic  hit_region;
    logic  hit_alias;

    assign alias_off  = addr - ALIAS_BASE;
    assign hit_region = in_window(addr, REGION_BASE, REGION_SPAN);
    assign hit_alias  = in_window(addr, ALIAS_BASE, ALIAS_SPAN);

    always_comb begin
        req.we    = we;
        req.wdata = wdata;
        if (hit_region) begin
            req.kind = ACC_PASS;
            req.tgt  = addr;
            req.bsel = '0;
        end else if (hit_alias) begin
            req.kind = ACC_ALIAS;
            req.tgt  = alias_target(alias_off, REGION_BASE);
            req.bsel = alias_bit(alias_off);
        end else begin
            req.kind = ACC_OOR;
            req.tgt  = '0;
            req.bsel = '0;
        end
    end

    // R2: every alias translation lands inside the normal region
    always_comb begin
        if (req.kind == ACC_ALIAS) begin
            p_tgt_in_region_r2: assert (in_window(req.tgt, REGION_BASE, REGION_SPAN))
                else $error("alias target outside region");
        end
    end

endmodule

// File: rtl/bab_bitlane.sv
module bab_bitlane
    import bab_pkg::*;
(
    input  word_t word,
    input  bidx_t bsel,
    input  logic  val,
    output word_t merged,
    output logic  picked
);

    for (genvar i = 0; i < WORD_W; i++) begin : g_lane
        assign merged[i] = (bsel == bidx_t'(i)) ? val : word[i];
    end

    assign picked = word[bsel];

endmodule

// File: rtl/bab_seq.sv
module bab_seq
    import bab_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     s_req,
    input  bus_req_t req_in,
    output logic     s_ready,
    output word_t    s_rdata,
    output logic     s_err,
    output logic     m_req,
    output logic     m_we,
    output logic     m_lock,
    output addr_t    m_addr,
    output word_t    m_wdata,
    input  logic     m_ready,
    input  word_t    m_rdata,
    output word_t    rword,
    output bidx_t    cur_bsel,
    output logic     cur_val,
    input  word_t    merged,
    input  logic     picked
);

    seq_state_e state;
    bus_req_t   req_q;
    word_t      rword_q;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            rword_q <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (s_req) begin
                        req_q   <= req_in;
                        rword_q <= '0;
                        err_q   <= (req_in.kind == ACC_OOR);
                        case (req_in.kind)
                            ACC_PASS:  state <= ST_PASS;
                            ACC_ALIAS: state <= ST_RD;
                            default:   state <= ST_DONE;
                        endcase
                    end
                end
                ST_PASS: begin
                    if (m_ready) begin
                        if (!req_q.we) rword_q <= m_rdata;
                        state <= ST_DONE;
                    end
                end
                ST_RD: begin
                    if (m_ready) begin
                        rword_q <= m_rdata;
                        state   <= req_q.we ? ST_WR : ST_DONE;
                    end
                end
                ST_WR: begin
                    if (m_ready) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                    err_q <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rword    = rword_q;
    assign cur_bsel = req_q.bsel;
    assign cur_val  = req_q.wdata[0];

    always_comb begin
        m_req   = (state == ST_PASS) || (state == ST_RD) || (state == ST_WR);
        m_we    = ((state == ST_PASS) && req_q.we) || (state == ST_WR);
        m_lock  = ((state == ST_RD) && req_q.we) || (state == ST_WR);
        m_addr  = m_req ? req_q.tgt : '0;
        if (state == ST_WR)                     m_wdata = merged;
        else if (state == ST_PASS && req_q.we)  m_wdata = req_q.wdata;
        else                                    m_wdata = '0;
    end

    always_comb begin
        s_ready = (state == ST_DONE);
        s_err   = s_ready && err_q;
        s_rdata = '0;
        if (s_ready && !req_q.we) begin
            if (req_q.kind == ACC_ALIAS)     s_rdata = {{(WORD_W-1){1'b0}}, picked};
            else if (req_q.kind == ACC_PASS) s_rdata = rword_q;
        end
    end

    // R8: a stalled master request keeps all of its fields
    p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
        m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));

    // R5: an accepted locked read is followed by a locked write to the same word
    p_lock_rd_to_wr_r5: assert property (@(posedge clk) disable iff (rst)
        m_req && m_ready && !m_we && m_lock |=> m_req && m_we && m_lock && $stable(m_addr));

    // R5: lock never appears without a request
    p_lock_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        m_lock |-> m_req);

    // R4: a locked write-back differs from the word read in at most one bit
    p_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
        m_req && m_we && m_lock |-> $countones(m_wdata ^ rword_q) <= 1);

    // R6: completion strobe is one cycle wide
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    // R3: alias read data has nothing above bit 0
    p_alias_rdata_r3: assert property (@(posedge clk) disable iff (rst)
        s_ready && req_q.kind == ACC_ALIAS |-> s_rdata[WORD_W-1:1] == '0);

    // R7: out-of-range completion never touches the memory port
    p_err_no_bus_r7: assert property (@(posedge clk) disable iff (rst)
        s_err |-> s_ready && !m_req && s_rdata == '0);

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
    import bab_pkg::*;
#(
    parameter addr_t       REGION_BASE  = 32'h2000_0000,
    parameter int unsigned REGION_WORDS = 1024,
    parameter addr_t       ALIAS_BASE   = 32'h2200_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_req,
    input  logic        s_we,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic [31:0] s_rdata,
    output logic        s_err,
    output logic        m_req,
    output logic        m_we,
    output logic        m_lock,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic        m_ready,
    input  logic [31:0] m_rdata
);

    bus_req_t dec_req;
    word_t    rword;
    word_t    merged;
    bidx_t    cur_bsel;
    logic     cur_val;
    logic     picked;

    bab_decode #(
        .REGION_BASE (REGION_BASE),
        .REGION_WORDS(REGION_WORDS),
        .ALIAS_BASE  (ALIAS_BASE)
    ) u_decode (
        .we   (s_we),
        .addr (s_addr),
        .wdata(s_wdata),
        .req  (dec_req)
    );

    bab_bitlane u_lane (
        .word  (rword),
        .bsel  (cur_bsel),
        .val   (cur_val),
        .merged(merged),
        .picked(picked)
    );

    bab_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .s_req   (s_req),
        .req_in  (dec_req),
        .s_ready (s_ready),
        .s_rdata (s_rdata),
        .s_err   (s_err),
        .m_req   (m_req),
        .m_we    (m_we),
        .m_lock  (m_lock),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .m_ready (m_ready),
        .m_rdata (m_rdata),
        .rword   (rword),
        .cur_bsel(cur_bsel),
        .cur_val (cur_val),
        .merged  (merged),
        .picked  (picked)
    );

endmodule

// File: tb/sim_bitalias_bridge.sv
module sim_bitalias_bridge;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RB         = 32'h2000_0000;
    localparam int          NW         = 1024;
    localparam logic [31:0] AB         = 32'h2200_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready, s_err;
    logic [31:0] s_rdata;
    logic        m_req, m_we, m_lock;
    logic [31:0] m_addr, m_wdata;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;

    logic [31:0] mem     [NW];
    logic [31:0] ref_mem [NW];

    int n_checks = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_lk = 0, n_rdy = 0, hold_err = 0;
    logic [31:0] last_addr = '0;
    logic        pend = 1'b0, pend_we = 1'b0;
    logic [31:0] pend_addr = '0, pend_wdata = '0;

    bitalias_bridge #(.REGION_BASE(RB), .REGION_WORDS(NW), .ALIAS_BASE(AB)) u0 (
        .clk(clk), .rst(rst), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata), .s_err(s_err),
        .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic in_reg(logic [31:0] a);
        return (a >= RB) && (a - RB < 32'(NW) * 4);
    endfunction

    function automatic int widx(logic [31:0] a);
        return int'((a - RB) >> 2);
    endfunction

    // memory model: drive response away from the clock edge
    always @(negedge clk) begin
        m_ready = ($urandom % 4) != 0;
        m_rdata = in_reg(m_addr) ? mem[widx(m_addr)] : 32'hDEAD_BEEF;
    end

    // monitor of master port
    always @(posedge clk) begin
        if (!rst) begin
            if (pend && !(m_req && m_addr == pend_addr && m_we == pend_we && m_wdata == pend_wdata))
                hold_err++;
            pend       = m_req && !m_ready;
            pend_addr  = m_addr;
            pend_we    = m_we;
            pend_wdata = m_wdata;
            if (s_ready) n_rdy++;
            if (m_req && m_ready) begin
                if (m_we) n_wr++; else n_rd++;
                if (m_lock) n_lk++;
                last_addr = m_addr;
                if (m_we && in_reg(m_addr)) mem[widx(m_addr)] = m_wdata;
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic err);
        bit done = 0;
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_lk = 0; n_rdy = 0;
        s_req = 1'b1; s_we = we; s_addr = addr; s_wdata = wd;
        rd = '0; err = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (s_ready) begin
                rd = s_rdata; err = s_err; done = 1;
                break;
            end
        end
        s_req = 1'b0;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R6 access timeout actual=%h expected=%h", 32'd0, 32'd1);
        end
        @(negedge clk);
        check("R6", "ready single pulse", 32'(n_rdy), 32'd1);
        check("R6", "ready low after", {31'd0, s_ready}, 32'd0);
    endtask

    task automatic pass_read(int w);
        logic [31:0] rd; logic err;
        access(1'b0, RB + 32'(w) * 4, $urandom, rd, err);
        check("R1", "pass read data", rd, ref_mem[w]);
        check("R1", "pass read one txn", 32'(n_rd * 16 + n_wr), 32'd16);
        check("R1", "pass addr unchanged", last_addr, RB + 32'(w) * 4);
        check("R5", "pass unlocked", 32'(n_lk), 32'd0);
    endtask

    task automatic pass_write(int w, logic [31:0] d);
        logic [31:0] rd; logic err;
        access(1'b1, RB + 32'(w) * 4, d, rd, err);
        ref_mem[w] = d;
        check("R1", "pass write stored", mem[w], ref_mem[w]);
        check("R1", "pass write one txn", 32'(n_rd * 16 + n_wr), 32'd1);
        check("R5", "pass write unlocked", 32'(n_lk), 32'd0);
    endtask

    task automatic alias_read(int w, int b, int lo);
        logic [31:0] rd; logic err;
        access(1'b0, AB + 32'(w) * 128 + 32'(b) * 4 + 32'(lo), $urandom, rd, err);
        check("R3", "alias read bit", rd, {31'd0, ref_mem[w][b]});
        check("R3", "alias read txns", 32'(n_rd * 16 + n_wr), 32'd16);
        check("R2", "alias read target", last_addr, RB + 32'(w) * 4);
        check("R5", "alias read unlocked", 32'(n_lk), 32'd0);
    endtask

    task automatic alias_write(int w, int b, int lo, logic [31:0] d);
        logic [31:0] rd; logic err;
        access(1'b1, AB + 32'(w) * 128 + 32'(b) * 4 + 32'(lo), d, rd, err);
        ref_mem[w][b] = d[0];
        check("R4", "alias write word", mem[w], ref_mem[w]);
        check("R4", "alias rmw txns", 32'(n_rd * 16 + n_wr), 32'd17);
        check("R2", "alias write target", last_addr, RB + 32'(w) * 4);
        check("R5", "both halves locked", 32'(n_lk), 32'd2);
    endtask

    task automatic oor(logic we, logic [31:0] a);
        logic [31:0] rd; logic err;
        access(we, a, $urandom, rd, err);
        check("R7", "err flag", {31'd0, err}, 32'd1);
        check("R7", "err rdata", rd, 32'd0);
        check("R7", "no master txn", 32'(n_rd + n_wr), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        int mism;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) begin
            mem[i]     = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
            ref_mem[i] = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
        end
        repeat (3) @(negedge clk);
        check("R9", "ready in reset", {31'd0, s_ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "quiet after reset", {29'd0, s_ready, m_req, m_lock}, 32'd0);

        // directed corner cases
        alias_read(0, 0, 0);
        alias_read(0, 31, 3);
        alias_write(0, 31, 0, 32'h0000_0000);
        alias_write(0, 31, 2, 32'h0000_0001);
        alias_write(NW - 1, 31, 1, 32'hFFFF_FFFE);   // R4: LSB 0 clears despite upper ones
        alias_write(NW - 1, 0, 0, 32'h0000_0001);
        alias_read(NW - 1, 31, 0);
        pass_write(5, 32'h0000_0000);
        alias_write(5, 17, 0, 32'hFFFF_FFFF);        // R4: exactly one bit set
        pass_read(5);
        pass_read(NW - 1);
        oor(1'b0, 32'h1000_0000);
        oor(1'b1, RB + 32'(NW) * 4);
        oor(1'b0, AB + 32'(NW) * 128);
        oor(1'b1, AB - 4);

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            int sel, w, b, lo;
            sel = int'($urandom % 10);
            w   = int'($urandom % NW);
            b   = int'($urandom % 32);
            lo  = int'($urandom % 4);
            case (sel)
                0, 1, 2: alias_write(w, b, lo, $urandom);
                3, 4, 5: alias_read(w, b, lo);
                6, 7:    pass_read(w);
                8:       pass_write(w, $urandom);
                default: oor(sel[0], 32'h3000_0000 + ($urandom & 32'h0FFF_FFFC));
            endcase
        end

        mism = 0;
        for (int i = 0; i < NW; i++) if (mem[i] !== ref_mem[i]) mism++;
        check("R4", "untouched bits and words intact", 32'(mism), 32'd0);
        check("R8", "stalled request held", 32'(hold_err), 32'd0);

        summary();
        $finish;
    end

endmodule